// File: doc/BRIEF.md
# Selectable Lookup Hash Generator

This block turns a variable-length lookup key into a 16-bit bucket index for a hashed flow table. The key is presented as a stream of 32-bit words, each qualified by `key_valid`, with `key_last` marking the final word. The block accepts a word on every cycle where `key_valid` is high. One cycle after the final word is taken, it raises `hash_done` for a single cycle and presents the hash on `hash_out`.

Two engines run in parallel on every key word. The first is a rolling-XOR accumulator: starting from zero, each word is folded in as `acc = rotl(acc,1) ^ word`. The second is a word-parallel CRC32 engine: it uses the reflected polynomial 0xEDB88320 and a preset of all ones, takes each word least significant bit first, and inverts the result at the end. A 2-bit mode selects how the 16-bit result is formed, and a swap bit optionally exchanges its two bytes. Both settings are captured with the first word of a key and held until that key completes.

The controller is a three-state machine. IDLE waits for a key. ACCUM holds a key that is part-way through. DONE is the single cycle that presents the result. The transitions are:
- `start_multi`: IDLE or DONE to ACCUM, on a valid word without last.
- `start_single`: IDLE or DONE to DONE, on a valid word with last.
- `finish`: ACCUM to DONE, on a valid word with last.
- `stay`: ACCUM to ACCUM, on no valid word or a word without last.
- `release`: DONE to IDLE, when no word arrives.

Top module: `key_hash_gen`

## Requirements
- R1: After reset, `hash_done` is 0 and `hash_out` is 0 until the first key completes.
- R2: Mode 0 (`cfg_mode`=2'd0) yields the XOR of the upper and lower 16-bit halves of the rolling-XOR accumulator, where acc starts at 0 and each word gives acc = rotl(acc,1) ^ word.
- R3: Mode 1 (`cfg_mode`=2'd1) yields the XOR of the upper and lower 16-bit halves of the final CRC32. The CRC32 uses reflected polynomial 0xEDB88320, preset 0xFFFFFFFF and final inversion, with each word taken bit 0 first.
- R4: Mode 2 (`cfg_mode`=2'd2) yields final CRC32 bits [15:0].
- R5: Mode 3 (`cfg_mode`=2'd3) yields final CRC32 bits [31:16].
- R6: When the swap bit is 1, bits [15:8] and [7:0] of the selected 16-bit value are exchanged.
- R7: Mode and swap are sampled with the first word of a key. Changes during the rest of the key have no effect on its result.
- R8: `hash_done` is high for exactly one cycle: the cycle after the edge that accepts the word marked last. `hash_out` is 0 whenever `hash_done` is 0.
- R9: Cycles with `key_valid` low in the middle of a key do not alter the result.
- R10: A new key may begin in the `hash_done` cycle. It starts from fresh accumulator state, and its own result follows with its own `hash_done`.
- R11: A key of a single word (valid and last together) completes with the same one-cycle timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Hash function select, sampled at first key word |
| cfg_swap | input | 1 | Byte swap of the result, sampled at first key word |
| key_valid | input | 1 | Key word qualifier; a word is accepted on every cycle it is high |
| key_last | input | 1 | Marks the final word of a key |
| key_word | input | 32 | Key data word |
| hash_out | output | 16 | Hash result, nonzero only while `hash_done` is high |
| hash_done | output | 1 | One-cycle completion strobe |

## Verification
On every cycle, the assertions check the completion timing: a last word is always followed by a done pulse, and no done pulse appears without one. They also check that the output stays zero outside done and that the captured mode and swap hold steady between first words. The numerical correctness of all four modes, with and without swap, can only be shown by the bench's sweeps, which compare against hashes computed arithmetically. Those sweeps also cover the effects of gaps, mid-key configuration changes and back-to-back keys.

// File: rtl/khg_pkg.sv
package khg_pkg;

    typedef enum logic [1:0] {
        HM_XOR_FOLD = 2'd0,
        HM_CRC_FOLD = 2'd1,
        HM_CRC_LO   = 2'd2,
        HM_CRC_HI   = 2'd3
    } hash_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DONE  = 2'd2
    } khg_state_e;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

endpackage

// File: rtl/khg_xor_accum.sv
module khg_xor_accum #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              first,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] acc
);
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] nxt;

    // A new key restarts from zero, so the rotated base is zero.
    always_comb begin
        base = first ? '0 : {acc[WORD_W-2:0], acc[WORD_W-1]};
        nxt  = base ^ word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (en)
            acc <= nxt;
    end
endmodule

// File: rtl/khg_crc_engine.sv
module khg_crc_engine #(
    parameter int          WORD_W = 32,
    parameter logic [31:0] POLY   = 32'hEDB8_8320,
    parameter logic [31:0] INIT   = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              first,
    input  logic [WORD_W-1:0] word,
    output logic [31:0]       crc_raw
);
    logic [31:0] seed;
    logic [31:0] nxt;

    // Reflected CRC: one unrolled step per data bit, bit 0 first.
    always_comb begin
        logic [31:0] c;
        seed = first ? INIT : crc_raw;
        c    = seed;
        for (int b = 0; b < WORD_W; b++) begin
            if (c[0] ^ word[b])
                c = (c >> 1) ^ POLY;
            else
                c = c >> 1;
        end
        nxt = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_raw <= INIT;
        else if (en)
            crc_raw <= nxt;
    end
endmodule

// File: rtl/khg_format.sv
module khg_format #(
    parameter int WORD_W = 32,
    parameter int HASH_W = 16
) (
    input  khg_pkg::hash_mode_e mode,
    input  logic                swap,
    input  logic [WORD_W-1:0]   xor_acc,
    input  logic [31:0]         crc_raw,
    output logic [HASH_W-1:0]   hash
);
    import khg_pkg::*;

    localparam int NBYTES = HASH_W / 8;

    logic [31:0]       crc_fin;
    logic [HASH_W-1:0] sel;
    logic [HASH_W-1:0] rev;

    assign crc_fin = ~crc_raw;

    always_comb begin
        unique case (mode)
            HM_XOR_FOLD: sel = xor_acc[WORD_W-1 -: HASH_W] ^ xor_acc[HASH_W-1:0];
            HM_CRC_FOLD: sel = crc_fin[31:16] ^ crc_fin[15:0];
            HM_CRC_LO:   sel = crc_fin[15:0];
            HM_CRC_HI:   sel = crc_fin[31:16];
            default:     sel = '0;
        endcase
    end

    // Byte order reversal of the selected value.
    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_rev
            assign rev[g*8 +: 8] = sel[(NBYTES-1-g)*8 +: 8];
        end
    endgenerate

    assign hash = swap ? rev : sel;
endmodule

// File: rtl/key_hash_gen.sv
module key_hash_gen #(
    parameter int WORD_W = 32,
    parameter int HASH_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_swap,
    input  logic              key_valid,
    input  logic              key_last,
    input  logic [WORD_W-1:0] key_word,
    output logic [HASH_W-1:0] hash_out,
    output logic              hash_done
);
    import khg_pkg::*;

    khg_state_e        state_q, state_d;
    hash_mode_e        mode_q;
    logic              swap_q;
    logic              first_w;
    logic [WORD_W-1:0] xor_acc;
    logic [31:0]       crc_raw;
    logic [HASH_W-1:0] hash_w;

    // A word that arrives outside ACCUM opens a new key.
    assign first_w = key_valid && (state_q != ST_ACCUM);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (key_valid && key_last)
                    state_d = ST_DONE;      // start_single
                else if (key_valid)
                    state_d = ST_ACCUM;     // start_multi
                else
                    state_d = ST_IDLE;      // release
            end
            ST_ACCUM: begin
                if (key_valid && key_last)
                    state_d = ST_DONE;      // finish
                else
                    state_d = ST_ACCUM;     // stay
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= HM_XOR_FOLD;
            swap_q <= 1'b0;
        end else if (first_w) begin
            mode_q <= hash_mode_e'(cfg_mode);
            swap_q <= cfg_swap;
        end
    end

    khg_xor_accum #(.WORD_W(WORD_W)) u_xor (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (key_valid),
        .first (first_w),
        .word  (key_word),
        .acc   (xor_acc)
    );

    khg_crc_engine #(
        .WORD_W (WORD_W),
        .POLY   (CRC_POLY),
        .INIT   (CRC_INIT)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (key_valid),
        .first   (first_w),
        .word    (key_word),
        .crc_raw (crc_raw)
    );

    khg_format #(.WORD_W(WORD_W), .HASH_W(HASH_W)) u_fmt (
        .mode    (mode_q),
        .swap    (swap_q),
        .xor_acc (xor_acc),
        .crc_raw (crc_raw),
        .hash    (hash_w)
    );

    always_comb begin
        hash_done = (state_q == ST_DONE);
        hash_out  = hash_done ? hash_w : '0;
    end
endmodule

// File: rtl/khg_checker.sv
module khg_checker #(
    parameter int HASH_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic              key_last,
    input logic              hash_done,
    input logic [HASH_W-1:0] hash_out,
    input logic              first_w,
    input logic [1:0]        mode_q,
    input logic              swap_q
);
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_last) |=> hash_done);

    a_r8_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hash_done) |-> $past(key_valid && key_last));

    a_r8_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hash_done |-> (hash_out == '0));

    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !first_w |=> ($stable(mode_q) && $stable(swap_q)));
endmodule

bind key_hash_gen khg_checker #(.HASH_W(HASH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_last  (key_last),
    .hash_done (hash_done),
    .hash_out  (hash_out),
    .first_w   (first_w),
    .mode_q    (mode_q),
    .swap_q    (swap_q)
);

// File: tb/sim_key_hash_gen.sv
`timescale 1ns/1ps
module sim_key_hash_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_swap = 1'b0;
    logic        key_valid = 1'b0;
    logic        key_last = 1'b0;
    logic [31:0] key_word = '0;
    logic [15:0] hash_out;
    logic        hash_done;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] seed = 32'h1357_9BDF;
    logic [31:0] kw [8];

    always #2.5 clk = ~clk;

    key_hash_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_swap(cfg_swap),
        .key_valid(key_valid), .key_last(key_last), .key_word(key_word),
        .hash_out(hash_out), .hash_done(hash_done)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Byte-wise reflected CRC32 over the key, bytes in ascending order.
    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int w = 0; w < len; w++) begin
            for (int by = 0; by < 4; by++) begin
                c = c ^ {24'd0, kw[w][by*8 +: 8]};
                for (int k = 0; k < 8; k++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    function automatic logic [15:0] ref_hash(input int len, input logic [1:0] m, input logic s);
        logic [31:0] a = '0;
        logic [31:0] c;
        logic [15:0] h;
        for (int w = 0; w < len; w++)
            a = ((a << 1) | (a >> 31)) ^ kw[w];
        c = ref_crc(len);
        case (m)
            2'd0: h = a[31:16] ^ a[15:0];
            2'd1: h = c[31:16] ^ c[15:0];
            2'd2: h = c[15:0];
            default: h = c[31:16];
        endcase
        return s ? {h[7:0], h[15:8]} : h;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one key. chg: flip cfg after the first word. gap: idle cycle between words.
    // nowait: drive first word in the current cycle. keep: leave caller to start the next key.
    task automatic send_key(input int len, input logic [1:0] m, input logic s,
                            input bit gap, input bit chg, input bit nowait, input bit keep,
                            input string req);
        logic [15:0] exp;
        for (int w = 0; w < len; w++) begin
            seed = next_rand(seed);
            kw[w] = seed;
        end
        exp = ref_hash(len, m, s);
        for (int w = 0; w < len; w++) begin
            if (!(w == 0 && nowait)) @(negedge clk);
            if (gap && w > 0) begin
                key_valid = 1'b0;
                key_word  = 32'hDEAD_BEEF;
                @(negedge clk);
            end
            key_valid = 1'b1;
            key_last  = (w == len - 1);
            key_word  = kw[w];
            cfg_mode  = (chg && w > 0) ? ~m : m;
            cfg_swap  = (chg && w > 0) ? ~s : s;
        end
        @(negedge clk);
        key_valid = 1'b0;
        key_last  = 1'b0;
        check({req, " done"}, {31'd0, hash_done}, 32'd1);
        check({req, " hash"}, {16'd0, hash_out}, {16'd0, exp});
        if (!keep) begin
            @(negedge clk);
            check("R8 done single cycle", {31'd0, hash_done}, 32'd0);
            check("R8 out quiet", {16'd0, hash_out}, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        string names [4] = '{"R2", "R3", "R4", "R5"};
        repeat (4) @(negedge clk);
        check("R1 done after reset", {31'd0, hash_done}, 32'd0);
        check("R1 out after reset", {16'd0, hash_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle done", {31'd0, hash_done}, 32'd0);

        // Sweep modes, swap and key lengths; len 1 covers R11.
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int len = 1; len <= 6; len++)
                    send_key(len, 2'(m), 1'(s), 1'b0, 1'b0, 1'b0, 1'b0,
                             (len == 1) ? {names[m], " R11"} : (s ? {names[m], " R6"} : names[m]));

        // R9: idle gaps inside keys.
        for (int m = 0; m < 4; m++)
            send_key(5, 2'(m), 1'(m & 1), 1'b1, 1'b0, 1'b0, 1'b0, "R9 gaps");

        // R7: configuration changed after first word.
        for (int m = 0; m < 4; m++)
            send_key(4, 2'(m), 1'(m >> 1), 1'b0, 1'b1, 1'b0, 1'b0, "R7 cfg held");

        // R10: back-to-back keys starting in the done cycle.
        send_key(3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10 first");
        send_key(2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R10 second");
        send_key(1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R10 R11 third");
        send_key(4, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10 fourth");

        repeat (3) @(negedge clk);
        check("R8 quiet at end", {31'd0, hash_done}, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule